// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the serial bit-rate tick for a transmitter from the system clock. It uses a numerically controlled oscillator. A 16-bit increment, which software places in the upper half of its control word, is added every clock cycle to a 20-bit phase accumulator that wraps around. Each time an addition carries out of the top accumulator bit, the block raises a one-cycle bit tick. The tick rate is therefore the increment times the clock frequency divided by 2^20. Fractional ratios are handled without an integer divider: the spacing between ticks alternates so that the long-run average matches the programmed rate exactly.

A second output, the character strobe, marks every tenth bit tick. That is the period of one frame of ten bits. It fires in the same cycle as the tick it belongs to. The whole timing chain runs only while the transmit enable bit is set. Clearing that bit holds both outputs low and returns the phase and the frame count to zero, so that the next enable starts a clean frame. A new increment value is used from the next clock edge on, with no reset needed.

Top module: `nco_baud_gen`

## Requirements
- R1: After reset, bitTick and charStrobe are low, and the phase and frame count are zero. With an increment of 0x8000, the first tick therefore appears in the 32nd cycle after the enable goes high.
- R2: Take the phase as starting from zero. After N enabled clock edges with a constant increment K, exactly floor(N*K/2^20) bit ticks have been seen. Each tick is high for one cycle, in the cycle that follows the edge whose addition carried out of bit 19.
- R3: An increment of 0 produces no bit tick and no character strobe, however long the enable stays high.
- R4: Because the increment is at most 0xFFFF, below 2^20/16, two bit ticks never occur in adjacent cycles.
- R5: charStrobe is high only together with bitTick. It marks the 10th, 20th, 30th, ... tick counted from a clear.
- R6: While txEnable is low, bitTick and charStrobe stay low.
- R7: Dropping txEnable for any number of cycles clears the phase and the frame count. After re-enable, the first tick and the first strobe come at the same cycles as after a reset.
- R8: A change of the increment while enabled takes effect from the next clock edge, without reset. With phase zero and a change from 0x8000 to 0x4000, the next tick comes 64 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ncoIncr | input | 16 | Phase increment per clock (control word bits 31:16) |
| txEnable | input | 1 | Transmit enable (control word bit 0); low clears and gates the chain |
| bitTick | output | 1 | One-cycle pulse per serial bit period |
| charStrobe | output | 1 | One-cycle pulse on every tenth bit tick |

## Verification
The hardest situation to reach from the ports is a change of enable or increment at a chosen phase. Examples are a disable in the middle of a frame, after five ticks with the phase partly filled, or a rate change at the exact cycle the phase has wrapped to zero. The phase itself cannot be seen, so the stimulus uses power-of-two increments whose tick spacing is exact. It counts cycles from each enable to land on known phase values. The first tick and strobe after the event then show whether the hidden state was cleared or kept.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Strobes from the frame control to the phase datapath
  typedef struct packed {
    logic clearPhase;   // force phase and tick register to zero
    logic stepPhase;    // add the increment this cycle
  } ncoStrobe_t;
endpackage

// File: rtl/nco_phase_path.sv
module nco_phase_path
  import nco_pkg::*;
#(
  parameter int INCR_W = 16,
  parameter int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ncoStrobe_t        strb,
  input  logic [INCR_W-1:0] incr,
  output logic              carryNext,
  output logic              tickQ,
  output logic [ACC_W-1:0]  phaseQ
);
  localparam int PAD_W = ACC_W - INCR_W + 1;

  logic [ACC_W:0] phaseSum;

  always_comb begin
    phaseSum  = {1'b0, phaseQ} + {{PAD_W{1'b0}}, incr};
    carryNext = phaseSum[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseQ <= '0;
      tickQ  <= 1'b0;
    end else if (strb.clearPhase) begin
      phaseQ <= '0;
      tickQ  <= 1'b0;
    end else if (strb.stepPhase) begin
      phaseQ <= phaseSum[ACC_W-1:0];
      tickQ  <= carryNext;
    end else begin
      tickQ  <= 1'b0;
    end
  end

  // R4: increment below 2^20/16 can never tick twice in a row
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickQ |=> !tickQ);

  // R3: a zero increment never produces a tick
  zero_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (incr == '0) |=> !tickQ);

  // R7: clearing returns the phase to zero
  clear_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearPhase |=> (phaseQ == '0));
endmodule

// File: rtl/nco_frame_ctrl.sv
module nco_frame_ctrl
  import nco_pkg::*;
#(
  parameter int BITS_PER_CHAR = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txEnable,
  input  logic       carryNext,
  output ncoStrobe_t strb,
  output logic       charStrobeQ
);
  localparam int CNT_W = $clog2(BITS_PER_CHAR);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS_PER_CHAR - 1);

  logic [CNT_W-1:0] bitCountQ;
  logic             tickComing;

  always_comb begin
    strb.clearPhase = !txEnable;
    strb.stepPhase  = txEnable;
    tickComing      = strb.stepPhase && carryNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCountQ   <= '0;
      charStrobeQ <= 1'b0;
    end else if (strb.clearPhase) begin
      bitCountQ   <= '0;
      charStrobeQ <= 1'b0;
    end else if (tickComing) begin
      if (bitCountQ == LAST_BIT) begin
        bitCountQ   <= '0;
        charStrobeQ <= 1'b1;
      end else begin
        bitCountQ   <= bitCountQ + 1'b1;
        charStrobeQ <= 1'b0;
      end
    end else begin
      charStrobeQ <= 1'b0;
    end
  end

  // R5: frame count stays inside the frame length
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitCountQ <= LAST_BIT);

  // R7: disable returns the frame count to zero
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txEnable |=> (bitCountQ == '0));
endmodule

// File: rtl/nco_baud_gen.sv
module nco_baud_gen
  import nco_pkg::*;
#(
  parameter int INCR_W        = 16,
  parameter int ACC_W         = 20,
  parameter int BITS_PER_CHAR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INCR_W-1:0] ncoIncr,
  input  logic              txEnable,
  output logic              bitTick,
  output logic              charStrobe
);
  ncoStrobe_t       strb;
  logic             carryNext;
  logic [ACC_W-1:0] phaseQ;

  nco_frame_ctrl #(.BITS_PER_CHAR(BITS_PER_CHAR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .txEnable(txEnable),
    .carryNext(carryNext), .strb(strb), .charStrobeQ(charStrobe)
  );

  nco_phase_path #(.INCR_W(INCR_W), .ACC_W(ACC_W)) u_path (
    .clk(clk), .rst_n(rst_n), .strb(strb), .incr(ncoIncr),
    .carryNext(carryNext), .tickQ(bitTick), .phaseQ(phaseQ)
  );

  // R5: strobe only together with a tick
  strobe_with_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    charStrobe |-> bitTick);

  // R6: disabled chain emits nothing on the next cycle
  gated_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txEnable |=> (!bitTick && !charStrobe));
endmodule

// File: tb/nco_baud_gen_bench.sv
module nco_baud_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ncoIncr = '0;
  logic        txEnable = 1'b0;
  logic        bitTick, charStrobe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nco_baud_gen u_nco_baud_gen (
    .clk(clk), .rst_n(rst_n), .ncoIncr(ncoIncr), .txEnable(txEnable),
    .bitTick(bitTick), .charStrobe(charStrobe)
  );

  task automatic check(string req, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // one clock edge, then sample at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // run n cycles, count ticks/strobes, record first tick/strobe cycle, adjacency
  task automatic run(int n, output int ticks, output int strobes,
                     output int firstTick, output int firstStrobe,
                     output int adjacent, output int loneStrobe);
    bit prev = 0;
    ticks = 0; strobes = 0; firstTick = -1; firstStrobe = -1;
    adjacent = 0; loneStrobe = 0;
    for (int i = 1; i <= n; i++) begin
      step();
      if (bitTick) begin
        ticks++;
        if (firstTick < 0) firstTick = i;
        if (prev) adjacent++;
      end
      if (charStrobe) begin
        strobes++;
        if (firstStrobe < 0) firstStrobe = i;
        if (!bitTick) loneStrobe++;
      end
      prev = bitTick;
    end
  endtask

  task automatic freshStart(logic [15:0] k);
    txEnable = 1'b0;
    step();
    ncoIncr  = k;
    txEnable = 1'b1;
  endtask

  task automatic testReset();
    int t, s, ft, fs, a, l;
    check("R1 bitTick at reset", int'(bitTick), 0);
    check("R1 charStrobe at reset", int'(charStrobe), 0);
    ncoIncr = 16'h8000; txEnable = 1'b1;
    run(40, t, s, ft, fs, a, l);
    check("R1 first tick cycle after reset", ft, 32);
  endtask

  task automatic testZero();
    int t, s, ft, fs, a, l;
    freshStart(16'h0000);
    run(500, t, s, ft, fs, a, l);
    check("R3 ticks with zero increment", t, 0);
    check("R3 strobes with zero increment", s, 0);
  endtask

  task automatic testPeriodic();
    int t, s, ft, fs, a, l;
    freshStart(16'h8000);
    run(320, t, s, ft, fs, a, l);
    check("R2 ticks 0x8000 over 320", t, 10);
    check("R5 strobes over 10 ticks", s, 1);
    check("R5 strobe on tenth tick", fs, 320);
    check("R5 strobe without tick", l, 0);
  endtask

  task automatic testFraction();
    int t, s, ft, fs, a, l;
    freshStart(16'h3000);
    run(1024, t, s, ft, fs, a, l);
    check("R2 ticks 0x3000 over 1024", t, 12);
    check("R2 first tick 0x3000", ft, 86);
  endtask

  task automatic testMax();
    int t, s, ft, fs, a, l;
    freshStart(16'hFFFF);
    run(2000, t, s, ft, fs, a, l);
    check("R2 ticks 0xFFFF over 2000", t, 124);
    check("R4 adjacent ticks", a, 0);
    check("R5 strobes 0xFFFF over 2000", s, 12);
    check("R5 strobe without tick", l, 0);
  endtask

  task automatic testDisable();
    int t, s, ft, fs, a, l;
    freshStart(16'h8000);
    run(170, t, s, ft, fs, a, l);
    check("R7 ticks before disable", t, 5);
    txEnable = 1'b0;
    run(3, t, s, ft, fs, a, l);
    check("R6 ticks while disabled", t, 0);
    run(50, t, s, ft, fs, a, l);
    check("R6 ticks while disabled long", t + s, 0);
    txEnable = 1'b1;
    run(320, t, s, ft, fs, a, l);
    check("R7 first tick after re-enable", ft, 32);
    check("R7 first strobe after re-enable", fs, 320);
  endtask

  task automatic testRateChange();
    int t, s, ft, fs, a, l;
    freshStart(16'h8000);
    run(32, t, s, ft, fs, a, l);
    check("R8 tick at old rate", ft, 32);
    ncoIncr = 16'h4000;
    run(70, t, s, ft, fs, a, l);
    check("R8 first tick at new rate", ft, 64);
    check("R8 ticks at new rate", t, 1);
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    testReset();
    testZero();
    testPeriodic();
    testFraction();
    testMax();
    testDisable();
    testRateChange();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule